// File: doc/BRIEF.md
# PHY Management Register Bridge

This block lets software reach the management registers of an external PHY through two 32-bit registers on a plain register bus. Software issues a single command write. That write carries the operation, the 5-bit PHY address, the 5-bit register address and, for writes, the 16-bit value. The block then runs a complete clause-22 management frame on MDC/MDIO.

Software polls the status register until the done flag that matches its command appears. That register also shows a busy flag and the last word read from the PHY. Reading the status register clears both done flags.

MDC runs at the system clock divided by `CLK_DIV`, which must be even and at least 4. Each bit period starts with MDC low for `CLK_DIV/2` cycles and ends with it high for the remaining cycles. The block changes MDIO shortly after MDC falls and samples MDIO at the cycle in which MDC is high for the first time. MDIO is split into `mdio_o`, `mdio_oe` and `mdio_i` for an external tri-state pad.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: A write to offset 0 with bit 13 set and bit 14 clear starts a write frame. Bits 4:0 give the PHY address, bits 12:8 the register address and bits 31:16 the data. The frame sends, MSB first, 32 ones, start 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 data bits. `mdio_oe` is high for all 64 bits.
- R2: Bit 14 set with bit 13 clear starts a read frame with opcode 10. The block drives only the first 46 bits and releases MDIO for the two turnaround bits and the 16 data bits. It samples those 16 data bits MSB first into status bits 31:16.
- R3: Each MDC period is `CLK_DIV` clocks, low first and high second. While no frame runs, MDC is low and `mdio_oe` is low.
- R4: Status (offset 1) layout: bits 31:16 hold the last read data, bit 2 is busy, bit 1 is read-done and bit 0 is write-done. Other bits read as 0, and offset 0 reads as 0.
- R5: A done flag sets only after the 64th bit period has fully ended, in the same cycle that busy falls. A read frame sets only read-done, and a write frame sets only write-done.
- R6: A bus read of the status register clears both done flags.
- R7: A command written while busy is ignored. The running frame continues unchanged and no second frame follows.
- R8: A command with both bits 14 and 13 set, or with neither set, starts no frame and leaves the done flags unchanged.
- R9: After reset, status reads 0, MDC is low and `mdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = command register, 1 = status register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally in the access cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
A command accepted at a clock edge raises busy at that edge. The first MDC rise follows `CLK_DIV/2` clocks later. The done flag is due at the end of the 64th MDC period, which is 64·`CLK_DIV` clocks after acceptance. The bench's PHY model counts MDC rising edges and captures MDIO at each one. It drives read data after each falling edge, so frame contents are checked bit by bit and do not depend on clock counts. Completion is checked by polling the status register until a done flag appears. At that moment the model must already have counted exactly 64 rising edges. Ignored and rejected commands are checked by waiting well past a full frame and then confirming that the edge count and status have not moved.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;

  localparam int CMD_RD_BIT = 14;
  localparam int CMD_WR_BIT = 13;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mgmt_op_e;

  typedef struct packed {
    mgmt_op_e    op;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_cmd_t;

  function automatic logic [FRAME_BITS-1:0] frame_of(mgmt_cmd_t c);
    logic [1:0]  ta;
    logic [15:0] body;
    ta   = (c.op == OP_RD) ? 2'b11 : 2'b10;
    body = (c.op == OP_RD) ? 16'hFFFF : c.wdata;
    return {{PRE_BITS{1'b1}}, 2'b01, c.op, c.phy, c.regad, ta, body};
  endfunction

endpackage

// File: rtl/phy_mgmt_clkdiv.sv
module phy_mgmt_clkdiv #(
  parameter int CLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic bit_start,
  output logic sample_pt,
  output logic bit_end
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = $clog2(CLK_DIV);

  logic [CW-1:0] cnt_q, cnt_nx;

  always_comb begin
    if (!run || cnt_q == CW'(CLK_DIV - 1)) cnt_nx = '0;
    else                                   cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      mdc   <= run && (cnt_nx >= CW'(HALF));
    end
  end

  assign bit_start = run && (cnt_q == '0);
  assign sample_pt = run && (cnt_q == CW'(HALF));
  assign bit_end   = run && (cnt_q == CW'(CLK_DIV - 1));

endmodule

// File: rtl/phy_mgmt_shifter.sv
module phy_mgmt_shifter
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mgmt_cmd_t   cmd,
  input  logic        bit_start,
  input  logic        sample_pt,
  input  logic        bit_end,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        frame_done,
  output logic        done_rd,
  output logic [15:0] rd_word
);
  localparam int BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [BW-1:0]         idx_q;
  logic                  rd_q;
  logic                  last_bit;

  assign last_bit   = (idx_q == BW'(FRAME_BITS - 1));
  assign frame_done = busy && bit_end && last_bit;
  assign done_rd    = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sh_q    <= '0;
      idx_q   <= '0;
      rd_q    <= 1'b0;
      rd_word <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      sh_q  <= frame_of(cmd);
      idx_q <= '0;
      rd_q  <= (cmd.op == OP_RD);
    end else if (busy) begin
      if (bit_start) begin
        mdio_o  <= sh_q[FRAME_BITS-1];
        mdio_oe <= !(rd_q && idx_q >= BW'(TA_POS));
        sh_q    <= {sh_q[FRAME_BITS-2:0], 1'b0};
      end
      if (sample_pt && rd_q && idx_q >= BW'(DATA_POS))
        rd_word <= {rd_word[14:0], mdio_i};
      if (bit_end) begin
        if (last_bit) begin
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          mdio_o  <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        busy,
  input  logic        frame_done,
  input  logic        done_rd,
  input  logic [15:0] rd_word,
  output logic        start,
  output mgmt_cmd_t   cmd,
  output logic        rd_flag,
  output logic        wr_flag
);
  logic        wr_cmd, rd_stat, go_rd, go_wr;
  logic [15:0] rdata_q;

  assign wr_cmd  = bus_cs && bus_we && !bus_addr;
  assign rd_stat = bus_cs && !bus_we && bus_addr;
  assign go_rd   = bus_wdata[CMD_RD_BIT];
  assign go_wr   = bus_wdata[CMD_WR_BIT];
  assign start   = wr_cmd && !busy && (go_rd ^ go_wr);

  always_comb begin
    cmd.op    = go_rd ? OP_RD : OP_WR;
    cmd.phy   = bus_wdata[4:0];
    cmd.regad = bus_wdata[12:8];
    cmd.wdata = bus_wdata[31:16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_flag <= 1'b0;
      wr_flag <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (frame_done && done_rd)       rd_flag <= 1'b1;
      else if (rd_stat)                rd_flag <= 1'b0;
      if (frame_done && !done_rd)      wr_flag <= 1'b1;
      else if (rd_stat)                wr_flag <= 1'b0;
      if (frame_done && done_rd)       rdata_q <= rd_word;
    end
  end

  assign bus_rdata = rd_stat ? {rdata_q, 13'b0, busy, rd_flag, wr_flag} : 32'h0;

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_cs,
  input  logic        bus_we,
  input  logic        bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic        busy, start, frame_done, done_rd;
  logic        bit_start, sample_pt, bit_end;
  logic        rd_flag, wr_flag;
  logic [15:0] rd_word;
  mgmt_cmd_t   cmd;

  phy_mgmt_regs u_regs (
    .clk, .rst_n, .bus_cs, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .busy, .frame_done, .done_rd, .rd_word,
    .start, .cmd, .rd_flag, .wr_flag
  );

  phy_mgmt_clkdiv #(.CLK_DIV(CLK_DIV)) u_div (
    .clk, .rst_n, .run(busy), .mdc, .bit_start, .sample_pt, .bit_end
  );

  phy_mgmt_shifter u_shift (
    .clk, .rst_n, .start, .cmd, .bit_start, .sample_pt, .bit_end, .mdio_i,
    .busy, .mdio_o, .mdio_oe, .frame_done, .done_rd, .rd_word
  );

endmodule

// File: rtl/phy_mgmt_ctrl_chk.sv
module phy_mgmt_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_cs,
  input logic        bus_we,
  input logic        bus_addr,
  input logic [31:0] bus_wdata,
  input logic        mdc,
  input logic        mdio_oe,
  input logic        busy,
  input logic        rd_flag,
  input logic        wr_flag
);
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R5
  rd_done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_flag) |-> $fell(busy));

  // R5
  wr_done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_flag) |-> $fell(busy));

  // R5
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_flag) |-> !$rose(wr_flag));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && !bus_we && bus_addr && !busy) |=> (!rd_flag && !wr_flag));

  // R8
  both_bits_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cs && bus_we && !bus_addr && bus_wdata[14] && bus_wdata[13] && !busy) |=> !busy);

endmodule

bind phy_mgmt_ctrl phy_mgmt_ctrl_chk u_chk (
  .clk, .rst_n, .bus_cs, .bus_we, .bus_addr, .bus_wdata,
  .mdc, .mdio_oe, .busy, .rd_flag, .wr_flag
);

// File: tb/phy_mgmt_ctrl_tb.sv
module phy_mgmt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  int          bitn = 0;
  logic [63:0] got_d, got_oe;
  logic [15:0] phy_val = '0;
  bit          phy_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_mgmt_ctrl #(.CLK_DIV(DIV)) u_dut (
    .clk, .rst_n, .bus_cs, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .mdc, .mdio_o, .mdio_oe, .mdio_i
  );

  // PHY model: capture at MDC rise, drive read data after MDC fall
  always @(posedge mdc) begin
    if (bitn < 64) begin
      got_d[63-bitn]  = mdio_o;
      got_oe[63-bitn] = mdio_oe;
    end
    bitn = bitn + 1;
  end

  always @(negedge mdc)
    if (phy_rd && bitn >= 48 && bitn < 64) mdio_i = phy_val[63-bitn];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                            input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, (op == 2'b10) ? 2'b11 : 2'b10, d};
  endfunction

  task automatic bus_write(input logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = d;
    @(negedge clk);
    bus_cs = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic a, output logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_cs = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic poll_done(output logic [31:0] s);
    for (int i = 0; i < 4000; i++) begin
      bus_read(1'b1, s);
      if (s[1] || s[0]) return;
    end
  endtask

  task automatic arm(input bit rd, input logic [15:0] v);
    bitn = 0; got_d = '0; got_oe = '0; phy_rd = rd; phy_val = v; mdio_i = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] s;
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 mdc/oe after reset", {mdc, mdio_oe}, 0);
    bus_read(1'b1, s);
    chk(s == 32'h0, "R9 status after reset", s, 0);
    bus_read(1'b0, s);
    chk(s == 32'h0, "R4 offset 0 reads zero", s, 0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] s;
    arm(0, '0);
    bus_write({d, 2'b00, 1'b1, rg, 3'b000, phy});
    bus_read(1'b1, s);
    chk(s[2] == 1'b1, "R4 busy during write frame", s, 32'h4);
    poll_done(s);
    chk(bitn == 64, "R5 write done after last bit", bitn, 64);
    chk(s[2:0] == 3'b001, "R5 write sets write-done only", s[2:0], 1);
    chk(got_d == exp_frame(2'b01, phy, rg, d), "R1 write frame bits", got_d, exp_frame(2'b01, phy, rg, d));
    chk(got_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R1 write frame drive", got_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    bus_read(1'b1, s);
    chk(s[1:0] == 2'b00, "R6 done cleared by read", s[1:0], 0);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v);
    logic [31:0] s;
    logic [63:0] e;
    e = exp_frame(2'b10, phy, rg, 16'h0);
    arm(1, v);
    bus_write({16'h0, 1'b0, 1'b1, 1'b0, rg, 3'b000, phy});
    poll_done(s);
    chk(bitn == 64, "R5 read done after last bit", bitn, 64);
    chk(s[2:0] == 3'b010, "R5 read sets read-done only", s[2:0], 2);
    chk(s[31:16] == v, "R2 read data", s[31:16], v);
    chk(got_d[63:18] == e[63:18], "R2 read frame header", got_d[63:18], e[63:18]);
    chk(got_oe == {{46{1'b1}}, 18'b0}, "R2 read frame release", got_oe, {{46{1'b1}}, 18'b0});
    bus_read(1'b1, s);
    chk(s[1:0] == 2'b00, "R6 read-done cleared by read", s[1:0], 0);
  endtask

  task automatic t_mdc();
    logic [31:0] s;
    time t0, t1, t2;
    arm(0, '0);
    bus_write({16'h1234, 2'b00, 1'b1, 5'd7, 3'b000, 5'd9});
    @(posedge mdc) t0 = $time;
    @(negedge mdc) t1 = $time;
    @(posedge mdc) t2 = $time;
    chk((t2 - t0) == DIV * CLK_PERIOD, "R3 mdc period", t2 - t0, DIV * CLK_PERIOD);
    chk((t1 - t0) == (DIV / 2) * CLK_PERIOD, "R3 mdc high time", t1 - t0, (DIV / 2) * CLK_PERIOD);
    poll_done(s);
    #1;
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R3 quiet when idle", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] s;
    arm(0, '0);
    bus_write({16'hBEEF, 2'b00, 1'b1, 5'd4, 3'b000, 5'd2});
    repeat (40) @(negedge clk);
    bus_write({16'h0, 1'b0, 1'b1, 1'b0, 5'd30, 3'b000, 5'd29});
    poll_done(s);
    chk(s[2:0] == 3'b001, "R7 only first command completes", s[2:0], 1);
    repeat (DIV * 80) @(negedge clk);
    chk(bitn == 64, "R7 no second frame", bitn, 64);
    chk(got_d == exp_frame(2'b01, 5'd2, 5'd4, 16'hBEEF), "R7 first frame intact",
        got_d, exp_frame(2'b01, 5'd2, 5'd4, 16'hBEEF));
    bus_read(1'b1, s);
    chk(s[2:0] == 3'b000, "R7 no late done", s[2:0], 0);
  endtask

  task automatic t_reject();
    logic [31:0] s;
    arm(0, '0);
    bus_write({16'hFFFF, 1'b0, 1'b1, 1'b1, 5'd3, 3'b000, 5'd3});
    bus_read(1'b1, s);
    chk(s[2] == 1'b0, "R8 both bits not busy", s[2], 0);
    repeat (DIV * 10) @(negedge clk);
    chk(bitn == 0, "R8 both bits no frame", bitn, 0);
    bus_write({16'hFFFF, 2'b00, 1'b0, 5'd3, 3'b000, 5'd3});
    repeat (DIV * 10) @(negedge clk);
    chk(bitn == 0, "R8 no op bit no frame", bitn, 0);
    bus_read(1'b1, s);
    chk(s[2:0] == 3'b000, "R8 status unchanged", s[2:0], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R5 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(5'h03, 5'h1F, 16'hA5C3);
    t_write(5'h00, 5'h00, 16'h0001);
    t_read(5'h11, 5'h02, 16'h8421);
    t_read(5'h1F, 5'h1F, 16'hFFFE);
    t_mdc();
    t_ignore();
    t_reject();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule